// File: doc/BRIEF.md
# Priority Multi-Field Packet Classifier

This block decides what to do with a packet from three header fields already pulled out of it: the IPv4 source address, the IPv4 destination address and the protocol byte. It holds a parameterized number of rules in registers. Each rule carries its own source prefix, destination prefix, a protocol value or a protocol wildcard, and an action code. A rule matches a packet only when every one of its fields matches.

Rules may overlap, so one packet can satisfy several of them. The block reports the action of the matching rule with the lowest index, because that rule has the highest priority. When no rule matches, it clears the hit flag and reports a fixed default action. Queries use a valid/ready handshake. The result appears one cycle after the query is accepted and is held while the consumer stalls. A separate write port loads or disables one rule per cycle.

Top module: `mf_rule_classifier`

## Requirements
- R1: After reset, `res_valid` is 0, `q_ready` is 1, and every rule is disabled, so the first query is reported as a miss.
- R2: When several enabled rules match a query, the result carries the action of the matching rule with the lowest index, and `res_hit` is 1.
- R3: Each address field is compared as a prefix. The length is an unsigned 6-bit value from 0 to 32, counted from bit 31 downward. Length 32 requires an exact match, and length 0 matches every address.
- R4: When a rule's protocol-wildcard bit is 1, the rule matches any protocol. When that bit is 0, the query's 8-bit protocol must equal the rule's protocol value.
- R5: When no enabled rule matches, `res_hit` is 0 and `res_action` equals the parameter `DEFAULT_ACT`, which is 8'hFF by default.
- R6: A rule written with `wr_valid` = 0 never matches, whatever its other fields hold.
- R7: A rule write at one clock edge is seen by queries accepted from the next edge on. A query accepted at the same edge as the write is evaluated against the rule as it was before the write.
- R8: A query is accepted at an edge where `q_valid` and `q_ready` are both 1. `res_valid` then rises at that same edge, so the result is available one cycle after the query was presented.
- R9: `q_ready` equals `!res_valid || res_ready`. While `res_valid` is 1 and `res_ready` is 0, the result and its flags stay unchanged. Results leave in the order their queries were accepted.
- R10: An address prefix length greater than 32 behaves as length 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_valid | input | 1 | Query present |
| q_ready | output | 1 | Query can be accepted |
| q_src | input | 32 | Source IPv4 address of the query |
| q_dst | input | 32 | Destination IPv4 address of the query |
| q_proto | input | 8 | Protocol byte of the query |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 1 | At least one rule matched |
| res_action | output | ACT_W | Action of the winning rule, or DEFAULT_ACT |
| wr_en | input | 1 | Write one rule |
| wr_idx | input | IDX_W | Index of the rule to write |
| wr_valid | input | 1 | Rule enabled |
| wr_src | input | 32 | Source prefix value |
| wr_src_len | input | 6 | Source prefix length |
| wr_dst | input | 32 | Destination prefix value |
| wr_dst_len | input | 6 | Destination prefix length |
| wr_proto | input | 8 | Protocol value |
| wr_proto_any | input | 1 | Protocol wildcard |
| wr_action | input | ACT_W | Action code |

## Verification
The bench builds rule sets that overlap and checks that a low-index match beats a catch-all rule with a higher index. A reversed priority encoder would return the catch-all action instead. It tests prefix lengths of 0, 16, 32 and 40. An off-by-one mask would then pass an address that should miss, and a length above 32 that was not clamped would turn an exact rule into a wildcard. It sends a query at the same edge that disables a rule, which exposes a design that bypasses new rule data into the comparison. It also stalls the result path and checks that the held result and the later result come out intact and in order. A design that ignored the stall would overwrite the first result or drop the second.

// File: rtl/mf_rule_classifier.sv
module mf_rule_classifier #(
  parameter int NUM_RULES = 8,
  parameter int ACT_W = 8,
  parameter logic [ACT_W-1:0] DEFAULT_ACT = '1,
  localparam int IDX_W = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_valid,
  output logic             q_ready,
  input  logic [31:0]      q_src,
  input  logic [31:0]      q_dst,
  input  logic [7:0]       q_proto,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_hit,
  output logic [ACT_W-1:0] res_action,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [31:0]      wr_src,
  input  logic [5:0]       wr_src_len,
  input  logic [31:0]      wr_dst,
  input  logic [5:0]       wr_dst_len,
  input  logic [7:0]       wr_proto,
  input  logic             wr_proto_any,
  input  logic [ACT_W-1:0] wr_action
);

  logic             en_r   [NUM_RULES];
  logic [31:0]      src_r  [NUM_RULES];
  logic [5:0]       slen_r [NUM_RULES];
  logic [31:0]      dst_r  [NUM_RULES];
  logic [5:0]       dlen_r [NUM_RULES];
  logic [7:0]       pro_r  [NUM_RULES];
  logic             pany_r [NUM_RULES];
  logic [ACT_W-1:0] act_r  [NUM_RULES];

  logic             any_hit;
  logic [ACT_W-1:0] win_act;
  logic             accept;

  function automatic logic [31:0] pfx_mask(input logic [5:0] len);
    if (len == 6'd0)       return 32'h0;
    else if (len >= 6'd32) return 32'hFFFF_FFFF;
    else                   return ~(32'hFFFF_FFFF >> len);
  endfunction

  function automatic logic pfx_hit(input logic [31:0] a, input logic [31:0] p,
                                   input logic [5:0] len);
    logic [31:0] m;
    m = pfx_mask(len);
    return ((a ^ p) & m) == 32'h0;
  endfunction

  assign q_ready = !res_valid || res_ready;
  assign accept  = q_valid && q_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_RULES; i++) begin
        en_r[i]   <= 1'b0;
        src_r[i]  <= '0;
        slen_r[i] <= '0;
        dst_r[i]  <= '0;
        dlen_r[i] <= '0;
        pro_r[i]  <= '0;
        pany_r[i] <= 1'b0;
        act_r[i]  <= '0;
      end
    end else if (wr_en) begin
      for (int i = 0; i < NUM_RULES; i++) begin
        if (i == int'(wr_idx)) begin
          en_r[i]   <= wr_valid;
          src_r[i]  <= wr_src;
          slen_r[i] <= wr_src_len;
          dst_r[i]  <= wr_dst;
          dlen_r[i] <= wr_dst_len;
          pro_r[i]  <= wr_proto;
          pany_r[i] <= wr_proto_any;
          act_r[i]  <= wr_action;
        end
      end
    end
  end

  always_comb begin
    any_hit = 1'b0;
    win_act = DEFAULT_ACT;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (en_r[i] && pfx_hit(q_src, src_r[i], slen_r[i]) &&
          pfx_hit(q_dst, dst_r[i], dlen_r[i]) &&
          (pany_r[i] || (q_proto == pro_r[i]))) begin
        any_hit = 1'b1;
        win_act = act_r[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_action <= DEFAULT_ACT;
    end else if (accept) begin
      res_valid  <= 1'b1;
      res_hit    <= any_hit;
      res_action <= win_act;
    end else if (res_ready) begin
      res_valid  <= 1'b0;
    end
  end

  // R8
  accept_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && q_ready |=> res_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_action) && $stable(res_hit));

  // R9
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> q_ready);

  // R5
  miss_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_action == DEFAULT_ACT);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !res_valid);

endmodule

// File: tb/mf_rule_classifier_tb.sv
module mf_rule_classifier_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        q_valid = 1'b0;
  logic        q_ready;
  logic [31:0] q_src = '0, q_dst = '0;
  logic [7:0]  q_proto = '0;
  logic        res_valid, res_hit;
  logic        res_ready = 1'b1;
  logic [7:0]  res_action;
  logic        wr_en = 1'b0, wr_valid = 1'b0, wr_proto_any = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_src = '0, wr_dst = '0;
  logic [5:0]  wr_src_len = '0, wr_dst_len = '0;
  logic [7:0]  wr_proto = '0, wr_action = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mf_rule_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_ready(q_ready),
    .q_src(q_src), .q_dst(q_dst), .q_proto(q_proto),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit),
    .res_action(res_action), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_valid(wr_valid), .wr_src(wr_src), .wr_src_len(wr_src_len),
    .wr_dst(wr_dst), .wr_dst_len(wr_dst_len), .wr_proto(wr_proto),
    .wr_proto_any(wr_proto_any), .wr_action(wr_action)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic put_rule(input int idx, input bit en, input logic [31:0] s, input int sl,
                          input logic [31:0] d, input int dl, input logic [7:0] p,
                          input bit pany, input logic [7:0] act);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_valid = en;
    wr_src = s; wr_src_len = 6'(sl); wr_dst = d; wr_dst_len = 6'(dl);
    wr_proto = p; wr_proto_any = pany; wr_action = act;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ask(input string req, input logic [31:0] s, input logic [31:0] d,
                     input logic [7:0] p, input bit ehit, input logic [7:0] eact);
    @(negedge clk);
    q_valid = 1'b1; q_src = s; q_dst = d; q_proto = p;
    @(negedge clk);
    q_valid = 1'b0;
    chk({req, " valid"}, 32'(res_valid), 32'd1);
    chk({req, " hit"}, 32'(res_hit), 32'(ehit));
    chk({req, " action"}, 32'(res_action), 32'(eact));
  endtask

  task automatic t_reset;
    chk("R1 res_valid", 32'(res_valid), 32'd0);
    chk("R1 q_ready", 32'(q_ready), 32'd1);
    ask("R1 R5 empty table", 32'h0A01_0203, 32'hC0A8_0105, 8'd6, 1'b0, 8'hFF);
  endtask

  task automatic t_prefix;
    put_rule(0, 1, 32'h0A01_0000, 16, 32'h0, 0, 8'd0, 1, 8'd1);
    put_rule(1, 1, 32'h0, 0, 32'hC0A8_0105, 32, 8'd0, 1, 8'd2);
    ask("R3 /16 inside", 32'h0A01_0203, 32'h0101_0101, 8'd6, 1'b1, 8'd1);
    ask("R3 /16 outside", 32'h0A02_0000, 32'h0101_0101, 8'd6, 1'b0, 8'hFF);
    ask("R3 /32 exact", 32'h0B00_0001, 32'hC0A8_0105, 8'd6, 1'b1, 8'd2);
    ask("R3 /32 neighbour", 32'h0B00_0001, 32'hC0A8_0104, 8'd6, 1'b0, 8'hFF);
  endtask

  task automatic t_proto;
    put_rule(2, 1, 32'h0, 0, 32'h0, 0, 8'd17, 0, 8'd3);
    ask("R4 proto equal", 32'h0B00_0001, 32'h0101_0101, 8'd17, 1'b1, 8'd3);
    ask("R4 proto differs", 32'h0B00_0001, 32'h0101_0101, 8'd6, 1'b0, 8'hFF);
  endtask

  task automatic t_priority;
    put_rule(3, 1, 32'h0, 0, 32'h0, 0, 8'd0, 1, 8'd4);
    ask("R2 rule0 over rule3", 32'h0A01_0909, 32'h0101_0101, 8'd6, 1'b1, 8'd1);
    ask("R2 rule2 over rule3", 32'h0B00_0001, 32'h0101_0101, 8'd17, 1'b1, 8'd3);
    ask("R2 only rule3", 32'h0B00_0001, 32'h0101_0101, 8'd6, 1'b1, 8'd4);
  endtask

  task automatic t_disable;
    put_rule(0, 0, 32'h0A01_0000, 16, 32'h0, 0, 8'd0, 1, 8'd1);
    ask("R6 disabled rule0", 32'h0A01_0909, 32'h0101_0101, 8'd6, 1'b1, 8'd4);
  endtask

  task automatic t_long_len;
    put_rule(1, 1, 32'h0, 0, 32'hC0A8_0105, 40, 8'd0, 1, 8'd5);
    ask("R10 len40 exact", 32'h0B00_0001, 32'hC0A8_0105, 8'd6, 1'b1, 8'd5);
    ask("R10 len40 neighbour", 32'h0B00_0001, 32'hC0A8_0104, 8'd6, 1'b1, 8'd4);
  endtask

  task automatic t_write_timing;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd3; wr_valid = 1'b0; wr_proto_any = 1'b1;
    q_valid = 1'b1; q_src = 32'h0B00_0001; q_dst = 32'h0101_0101; q_proto = 8'd6;
    @(negedge clk);
    wr_en = 1'b0; q_valid = 1'b0;
    chk("R7 same-edge hit", 32'(res_hit), 32'd1);
    chk("R7 same-edge action", 32'(res_action), 32'd4);
    ask("R7 after write", 32'h0B00_0001, 32'h0101_0101, 8'd6, 1'b0, 8'hFF);
  endtask

  task automatic t_stall;
    @(negedge clk);
    res_ready = 1'b0; q_valid = 1'b1;
    q_src = 32'h0B00_0001; q_dst = 32'h0101_0101; q_proto = 8'd17;
    @(negedge clk);
    chk("R8 first valid", 32'(res_valid), 32'd1);
    chk("R8 first action", 32'(res_action), 32'd3);
    chk("R9 ready low", 32'(q_ready), 32'd0);
    q_dst = 32'hC0A8_0105; q_proto = 8'd6;
    @(negedge clk);
    chk("R9 held valid", 32'(res_valid), 32'd1);
    chk("R9 held action", 32'(res_action), 32'd3);
    chk("R9 still blocked", 32'(q_ready), 32'd0);
    res_ready = 1'b1;
    #1;
    chk("R9 ready follows res_ready", 32'(q_ready), 32'd1);
    @(negedge clk);
    q_valid = 1'b0;
    chk("R9 second valid", 32'(res_valid), 32'd1);
    chk("R9 second action", 32'(res_action), 32'd5);
    @(negedge clk);
    chk("R8 drained", 32'(res_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_prefix();
    t_proto();
    t_priority();
    t_disable();
    t_long_len();
    t_write_timing();
    t_stall();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule